// File: doc/BRIEF.md
# Debug Program Counter Display Controller

This block presents processor debug state on a four-digit seven-segment display and a row of status LEDs. It receives two 32-bit program counters: the address of the most recently retired instruction, delivered with a retire strobe, and the address the front end is fetching now. Two slide switches pick the source and the 16-bit half of that source. A push button copies the selected half into a hold register. The display shows that register and nothing else, so a fast-moving counter stays readable.

The raw button passes through a two-stage synchronizer and a counter-based debounce filter. Each accepted press yields exactly one capture pulse. Seven status flags drive the LEDs directly. A second push button, the centre one, is the block's synchronous active-low reset. The four digits share one segment bus and are lit in turn by a free-running refresh counter. Anode enables and segment lines are both active-low.

Top module: `dbg_pc_display`

## Requirements
- R1: After reset the hold register reads 0x0000, so all four digits show `0`, and the retired-PC register holds 0xDEADBEEF until the first retire strobe.
- R2: With `src_fetch_sw` low, a capture takes its value from the retired-PC register.
- R3: With `src_fetch_sw` high, a capture takes its value from the fetch address, registered one cycle.
- R4: With `half_hi_sw` high, a capture takes bits 31:16 of the selected source. With it low, it takes bits 15:0.
- R5: Changing either switch without pressing the button leaves the displayed digits unchanged.
- R6: A button level that returns low before it has been stable for `DEB_CYC` cycles after synchronization causes no capture.
- R7: One press gives exactly one capture. Holding the button captures nothing further, and releasing it captures nothing.
- R8: Each digit decodes its nibble 0..F to the usual hex glyphs. `seg_n[0]` is segment a and `seg_n[6]` is segment g, with a segment lit when its line is 0. For example, 0 lights a–f and 8 lights all seven.
- R9: Exactly one `digit_n` line is low at any time. `digit_n[k]` shows bits 4k+3:4k of the hold register. The digits are lit in the order 0,1,2,3,0 and each is held for `REFRESH_CYC` cycles.
- R10: `dp_n` stays high, so the decimal point is always off.
- R11: `led[k]` equals `status_flags[k]`. The bits are: 0 debug break, 1 I/O buffer full, 2 store buffer full, 3 load buffer full, 4 ALU reservation station full, 5 reorder buffer full, 6 load/store queue full.
- R12: The retired-PC register loads `commit_pc` only in cycles where `commit_vld` is high.
- R13: When a retire strobe and a capture act on the same clock edge, the capture stores the retired PC as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Centre button, synchronous active-low reset |
| commit_pc | input | 32 | Address of the retiring instruction |
| commit_vld | input | 1 | Retire strobe qualifying `commit_pc` |
| fetch_pc | input | 32 | Address currently being fetched |
| src_fetch_sw | input | 1 | Source switch: 0 retired PC, 1 fetch PC |
| half_hi_sw | input | 1 | Half switch: 0 bits 15:0, 1 bits 31:16 |
| upd_btn | input | 1 | Raw, asynchronous update button |
| status_flags | input | 7 | Pipeline status flags, mapped as in R11 |
| led | output | 7 | Status LEDs, active-high |
| seg_n | output | 7 | Segments a..g in bits 0..6, active-low |
| dp_n | output | 1 | Decimal point, active-low, held off |
| digit_n | output | 4 | Digit enables, active-low |

## Verification
A capture and a retirement can act on the same clock edge. In that case the hold register must sample the retired-PC register before that register takes its new value. The bench counts the synchronizer and debounce stages from the press. It then raises `commit_vld` with a fresh address in exactly the cycle whose edge loads the hold register. It judges the result by reading the digits: they must show the old retired address. A second press must then show the new one.

// File: rtl/dbg_disp_pkg.sv
// Package: shared constants, selector encodings and the hex glyph table
// for the debug PC display. Assumes segment bit 0 is segment a.
package dbg_disp_pkg;

    localparam int NIBBLE_W = 4;
    localparam int SEG_W    = 7;

    // Source selector encoding (matches the switch level).
    typedef enum logic {
        PC_SRC_RETIRED = 1'b0,
        PC_SRC_FETCH   = 1'b1
    } pc_src_e;

    // Half selector encoding (matches the switch level).
    typedef enum logic {
        PC_HALF_LOW  = 1'b0,
        PC_HALF_HIGH = 1'b1
    } pc_half_e;

    // Active-high glyph for one hex nibble; bit 0 = a ... bit 6 = g.
    function automatic logic [SEG_W-1:0] nibble_glyph(input logic [NIBBLE_W-1:0] nib);
        logic [SEG_W-1:0] g;
        unique case (nib)
            4'h0: g = 7'b0111111;
            4'h1: g = 7'b0000110;
            4'h2: g = 7'b1011011;
            4'h3: g = 7'b1001111;
            4'h4: g = 7'b1100110;
            4'h5: g = 7'b1101101;
            4'h6: g = 7'b1111101;
            4'h7: g = 7'b0000111;
            4'h8: g = 7'b1111111;
            4'h9: g = 7'b1101111;
            4'hA: g = 7'b1110111;
            4'hB: g = 7'b1111100;
            4'hC: g = 7'b0111001;
            4'hD: g = 7'b1011110;
            4'hE: g = 7'b1111001;
            default: g = 7'b1110001;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/btn_capture.sv
// Module: btn_capture
// Turns a raw, bouncing, asynchronous push button into a single-cycle
// pulse on each accepted press. Assumes SYNC_STAGES >= 2 and DEB_CYC >= 1.
// A level is accepted once it has been stable for DEB_CYC cycles after
// synchronisation; only the low-to-high acceptance emits a pulse.
module btn_capture #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press_pulse
);

    localparam int CNT_W = $clog2(DEB_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   btn_s;
    logic [CNT_W-1:0]       dwell_q;
    logic                   level_q;
    logic                   pulse_q;

    // Shift the raw button through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
    end

    assign btn_s = sync_q[SYNC_STAGES-1];

    // Count how long the synchronised level has differed from the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (btn_s == level_q) begin
                dwell_q <= '0;
            end else if (dwell_q == CNT_LAST) begin
                dwell_q <= '0;
                level_q <= btn_s;
                pulse_q <= btn_s;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end
    end

    assign press_pulse = pulse_q;

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);

endmodule

// File: rtl/pc_capture.sv
// Module: pc_capture
// Tracks the retired PC (loaded on its strobe) and the fetch PC, selects
// a source and a half by two switch levels, and loads the hold register
// only on a capture pulse. Assumes PC_W == 2 * DISP_W.
module pc_capture
    import dbg_disp_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter int          DISP_W     = 16,
    parameter logic [31:0] RETIRE_RST = 32'hDEAD_BEEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   commit_pc,
    input  logic              commit_vld,
    input  logic [PC_W-1:0]   fetch_pc,
    input  pc_src_e           src_sel,
    input  pc_half_e          half_sel,
    input  logic              capture,
    output logic [DISP_W-1:0] disp_val
);

    logic [PC_W-1:0]   retired_q;
    logic [PC_W-1:0]   fetch_q;
    logic [PC_W-1:0]   src_val;
    logic [DISP_W-1:0] half_val;
    logic [DISP_W-1:0] hold_q;

    // Keep the last retired address; reset to the marker pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)          retired_q <= PC_W'(RETIRE_RST);
        else if (commit_vld) retired_q <= commit_pc;
    end

    // Register the fetch address to cut the path from the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= '0;
        else        fetch_q <= fetch_pc;
    end

    // Pick the source, then the half, from the switch levels.
    always_comb begin
        src_val  = (src_sel == PC_SRC_FETCH) ? fetch_q : retired_q;
        half_val = (half_sel == PC_HALF_HIGH) ? src_val[PC_W-1 -: DISP_W]
                                              : src_val[DISP_W-1:0];
    end

    // Load the hold register only on a capture pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= half_val;
    end

    assign disp_val = hold_q;

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(disp_val));

    // R1
    retire_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (retired_q == PC_W'(RETIRE_RST)));

endmodule

// File: rtl/seg_scan.sv
// Module: seg_scan
// Time-multiplexes a packed hex value over DIGITS seven-segment digits.
// Each digit is held for REFRESH_CYC cycles. Anodes and segments are
// active-low. Assumes DIGITS >= 2 and REFRESH_CYC >= 2.
module seg_scan
    import dbg_disp_pkg::*;
#(
    parameter int DIGITS      = 4,
    parameter int REFRESH_CYC = 100_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIGITS*NIBBLE_W-1:0] value,
    output logic [SEG_W-1:0]           seg_n,
    output logic                       dp_n,
    output logic [DIGITS-1:0]          digit_n
);

    localparam int REF_W = $clog2(REFRESH_CYC + 1);
    localparam int IDX_W = $clog2(DIGITS);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFRESH_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

    logic [REF_W-1:0]    ref_q;
    logic                step;
    logic [IDX_W-1:0]    idx_q;
    logic [NIBBLE_W-1:0] nib;

    // Free-running dwell counter for one digit slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_q <= '0;
        else if (step) ref_q <= '0;
        else           ref_q <= ref_q + 1'b1;
    end

    assign step = (ref_q == REF_LAST);

    // Advance to the next digit at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (step) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end

    // Select the nibble that belongs to the active digit.
    always_comb begin
        nib = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (idx_q == IDX_W'(i)) nib = value[i*NIBBLE_W +: NIBBLE_W];
        end
    end

    // One anode per digit, low while that digit is active.
    for (genvar g = 0; g < DIGITS; g++) begin : g_anode
        assign digit_n[g] = (idx_q != IDX_W'(g));
    end

    assign seg_n = ~nibble_glyph(nib);
    assign dp_n  = 1'b1;

    // R9
    one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~digit_n) == 1);

    // R9
    digit_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_n) |-> $past(step));

endmodule

// File: rtl/dbg_pc_display.sv
// Module: dbg_pc_display (top)
// Debug front panel: button-triggered capture of a selected PC half onto a
// multiplexed hex display, plus direct status LEDs. Assumes rst_n is the
// already-synchronous centre button and upd_btn is raw and asynchronous.
module dbg_pc_display
    import dbg_disp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int DIGITS      = 4,
    parameter int FLAG_N      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 500_000,
    parameter int REFRESH_CYC = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   commit_pc,
    input  logic              commit_vld,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              src_fetch_sw,
    input  logic              half_hi_sw,
    input  logic              upd_btn,
    input  logic [FLAG_N-1:0] status_flags,
    output logic [FLAG_N-1:0] led,
    output logic [SEG_W-1:0]  seg_n,
    output logic              dp_n,
    output logic [DIGITS-1:0] digit_n
);

    localparam int DISP_W = DIGITS * NIBBLE_W;

    logic              cap_pulse;
    logic [DISP_W-1:0] disp_val;
    pc_src_e           src_sel;
    pc_half_e          half_sel;

    // Map switch levels onto the selector encodings.
    assign src_sel  = pc_src_e'(src_fetch_sw);
    assign half_sel = pc_half_e'(half_hi_sw);

    btn_capture #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_CYC     (DEB_CYC)
    ) u_btn (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_raw     (upd_btn),
        .press_pulse (cap_pulse)
    );

    pc_capture #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_pc  (commit_pc),
        .commit_vld (commit_vld),
        .fetch_pc   (fetch_pc),
        .src_sel    (src_sel),
        .half_sel   (half_sel),
        .capture    (cap_pulse),
        .disp_val   (disp_val)
    );

    seg_scan #(
        .DIGITS      (DIGITS),
        .REFRESH_CYC (REFRESH_CYC)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .value   (disp_val),
        .seg_n   (seg_n),
        .dp_n    (dp_n),
        .digit_n (digit_n)
    );

    // Status flags light their LEDs directly.
    assign led = status_flags;

endmodule

// File: tb/dbg_pc_display_tb.sv
module dbg_pc_display_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int REF        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] commit_pc = '0;
    logic        commit_vld = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        src_fetch_sw = 1'b0;
    logic        half_hi_sw = 1'b0;
    logic        upd_btn = 1'b0;
    logic [6:0]  status_flags = '0;
    logic [6:0]  led;
    logic [6:0]  seg_n;
    logic        dp_n;
    logic [3:0]  digit_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_pc_display #(
        .DEB_CYC     (DEB),
        .REFRESH_CYC (REF)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_pc    (commit_pc),
        .commit_vld   (commit_vld),
        .fetch_pc     (fetch_pc),
        .src_fetch_sw (src_fetch_sw),
        .half_hi_sw   (half_hi_sw),
        .upd_btn      (upd_btn),
        .status_flags (status_flags),
        .led          (led),
        .seg_n        (seg_n),
        .dp_n         (dp_n),
        .digit_n      (digit_n)
    );

    // Expected active-high glyph, bit 0 = segment a (from R8).
    function automatic logic [6:0] glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
            4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
            4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
            4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Full press: hold long enough to be accepted, then release and settle.
    task automatic press();
        @(negedge clk);
        upd_btn = 1'b1;
        repeat (DEB + 6) @(negedge clk);
        upd_btn = 1'b0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    // Walk all four digit slots and compare segments and decimal point.
    task automatic check_display(input string req, input logic [15:0] exp);
        logic        bad = 1'b0;
        logic [27:0] got = '0;
        logic [27:0] want = '0;
        for (int d = 0; d < 4; d++) begin
            int guard = 0;
            while (digit_n !== ~(4'b0001 << d) && guard < 64) begin
                @(negedge clk);
                guard++;
            end
            got[d*7 +: 7]  = seg_n;
            want[d*7 +: 7] = ~glyph(exp[d*4 +: 4]);
            if (guard >= 64 || seg_n !== ~glyph(exp[d*4 +: 4]) || dp_n !== 1'b1) bad = 1'b1;
        end
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: display segs=%h dp_n=%b, expected segs=%h for value %h dp_n=1",
                     req, got, dp_n, want, exp);
        end
    endtask

    task automatic t_reset();
        do_reset();
        // R1: hold register clears to zero
        check_display("R1", 16'h0000);
    endtask

    task automatic t_retired_marker();
        src_fetch_sw = 1'b0; half_hi_sw = 1'b1;
        press();
        // R1 R2 R4: marker upper half from the retired register
        check_display("R1/R2", 16'hDEAD);
        half_hi_sw = 1'b0;
        press();
        check_display("R2/R4", 16'hBEEF);
    endtask

    task automatic t_fetch_halves();
        src_fetch_sw = 1'b1;
        fetch_pc = 32'h0123_4567;
        half_hi_sw = 1'b0;
        press();
        // R3 R8: fetch low half, glyphs 4..7
        check_display("R3/R8", 16'h4567);
        half_hi_sw = 1'b1;
        press();
        // R4 R8: fetch high half, glyphs 0..3
        check_display("R4/R8", 16'h0123);
        fetch_pc = 32'h89AB_CDEF;
        press();
        check_display("R8", 16'h89AB);
        half_hi_sw = 1'b0;
        press();
        check_display("R8", 16'hCDEF);
    endtask

    task automatic t_switch_only();
        // R5: switches move, display holds CDEF
        src_fetch_sw = 1'b0;
        repeat (10) @(negedge clk);
        check_display("R5", 16'hCDEF);
        half_hi_sw = 1'b1;
        repeat (10) @(negedge clk);
        check_display("R5", 16'hCDEF);
    endtask

    task automatic t_retire_strobe();
        src_fetch_sw = 1'b0; half_hi_sw = 1'b0;
        @(negedge clk);
        commit_pc = 32'h0000_1234;
        commit_vld = 1'b0;
        repeat (3) @(negedge clk);
        press();
        // R12: no strobe, register still holds the marker
        check_display("R12", 16'hBEEF);
        @(negedge clk);
        commit_vld = 1'b1;
        @(negedge clk);
        commit_vld = 1'b0;
        commit_pc = 32'h0000_9999;
        press();
        check_display("R12", 16'h1234);
    endtask

    task automatic t_glitch();
        fetch_pc = 32'h0000_AAAA;
        src_fetch_sw = 1'b1;
        @(negedge clk);
        upd_btn = 1'b1;
        repeat (DEB - 2) @(negedge clk);
        upd_btn = 1'b0;
        repeat (DEB + 8) @(negedge clk);
        // R6: short pulse rejected, display keeps 1234
        check_display("R6", 16'h1234);
    endtask

    task automatic t_hold_once();
        fetch_pc = 32'h0000_5A5A;
        @(negedge clk);
        upd_btn = 1'b1;
        repeat (DEB + 6) @(negedge clk);
        fetch_pc = 32'h0000_0F0F;
        repeat (5 * DEB) @(negedge clk);
        // R7: held button captured only once
        check_display("R7", 16'h5A5A);
        upd_btn = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        // R7: release captures nothing
        check_display("R7", 16'h5A5A);
    endtask

    task automatic t_same_cycle();
        src_fetch_sw = 1'b0; half_hi_sw = 1'b0;
        @(negedge clk);
        commit_pc = 32'h0000_1111; commit_vld = 1'b1;
        @(negedge clk);
        commit_vld = 1'b0;
        repeat (2) @(negedge clk);
        upd_btn = 1'b1;
        // 2 sync stages + DEB filter edges, then the pulse edge
        repeat (DEB + 2) @(posedge clk);
        @(negedge clk);
        commit_pc = 32'h0000_2222; commit_vld = 1'b1;
        @(negedge clk);
        commit_vld = 1'b0;
        repeat (DEB) @(negedge clk);
        upd_btn = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        // R13: coinciding strobe not seen by this capture
        check_display("R13", 16'h1111);
        press();
        check_display("R13", 16'h2222);
    endtask

    task automatic t_scan();
        logic [3:0] prev;
        int         dwell = 0;
        int         bad = 0;
        logic       seen_change = 1'b0;
        @(negedge clk);
        prev = digit_n;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if ($countones(~digit_n) != 1) bad++;
            if (digit_n !== prev) begin
                logic [3:0] nxt = {prev[2:0], prev[3]};
                if (digit_n !== nxt) bad++;
                if (seen_change && dwell != REF) bad++;
                seen_change = 1'b1;
                dwell = 1;
                prev = digit_n;
            end else begin
                dwell++;
            end
        end
        n_checks++;
        // R9: one-hot low anodes, order 0..3, dwell REF
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R9: %0d scan violations, last digit_n=%b, expected 0 violations", bad, digit_n);
        end
        n_checks++;
        // R10: decimal point off
        if (dp_n !== 1'b1) begin
            n_fail++;
            $display("FAIL R10: dp_n=%b expected 1", dp_n);
        end
    endtask

    task automatic t_leds();
        for (int k = 0; k <= 7; k++) begin
            @(negedge clk);
            status_flags = (k == 7) ? 7'h7F : 7'(1 << k);
            #1;
            n_checks++;
            // R11: each flag drives its own LED
            if (led !== status_flags) begin
                n_fail++;
                $display("FAIL R11: led=%b expected %b", led, status_flags);
            end
        end
        status_flags = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_retired_marker();
        t_fetch_halves();
        t_switch_only();
        t_retire_strobe();
        t_glitch();
        t_hold_once();
        t_same_cycle();
        t_scan();
        t_leds();
        summary();
        $finish;
    end

endmodule